// File: doc/BRIEF.md
# Infrared Serial Pulse Encoder

This block sits between a UART transmitter and an infrared transceiver. It turns the serial bit stream into infrared pulses. A zero bit becomes one short high pulse near the middle of the bit. A one bit leaves the light off. It also switches the line pins between plain serial and infrared operation, and it can route the infrared output back into the receive path for self-test. Decoding of received pulses happens elsewhere.

Bit timing comes from a 16x oversampling tick. A separate bit-start strobe, asserted together with the tick that opens each bit, marks the bit boundaries. Two pulse-width modes exist:

- **Normal mode:** the pulse covers phases 7 to 9 of the 16 phases, so it lasts 3/16 of a bit.
- **Low-power mode:** the pulse starts at the same point but lasts three periods of a separate low-power reference tick, whatever the bit rate.

Top module: `sir_pulse_enc`

## Requirements
- R1: In normal mode a zero bit drives `sir_out` high for exactly three 16x tick intervals. It rises on the second clock after the tick that moves the bit phase from 6 to 7, and falls on the second clock after the tick that moves it from 9 to 10. The bit-start tick sets the phase to 0, and each later tick adds one, saturating at 15.
- R2: In low-power mode a zero bit drives `sir_out` high from the second clock after the tick that moves the phase to 7. It stays high until the second clock after the third `lp_tick` that follows that tick. Its width therefore does not depend on the 16x tick rate.
- R3: While infrared operation is inactive, `sir_out` stays 0 and `sir_dec_in` is held at 1 whatever `sir_rx_pin` does.
- R4: While infrared operation is active (`uart_en` and `sir_en` both 1), `uart_txd` is held at 1 and `uart_rx_core` is held at 1. Otherwise `uart_txd` follows `tx_bit` and `uart_rx_core` follows `uart_rx_pin`.
- R5: With `uart_en` at 0, `sir_en` has no effect: no pulses are produced and the plain pins pass through.
- R6: With infrared active and both `loop_en` and `sir_test` at 1, `sir_dec_in` equals the inverse of `sir_out`. With infrared active and either of them at 0, `sir_dec_in` follows `sir_rx_pin`.
- R7: A one bit produces no pulse. Two clocks after a bit-start tick, `sir_out` is 0, so no pulse runs across a bit boundary.
- R8: After reset, `sir_out` is 0 and no pulse is produced until a bit-start tick has loaded a zero bit.
- R9: The pulse mode is sampled from `lowpow_en` at the bit-start tick and is held for the whole bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uart_en | input | 1 | Global UART enable |
| sir_en | input | 1 | Infrared mode enable |
| lowpow_en | input | 1 | Low-power pulse width select |
| loop_en | input | 1 | Loopback enable |
| sir_test | input | 1 | Infrared test mode, allows infrared loopback |
| baud_tick | input | 1 | 16x oversampling tick, one clock wide |
| bit_start | input | 1 | Marks the tick that opens a new bit |
| tx_bit | input | 1 | Serial transmit stream, 1 = idle/mark |
| lp_tick | input | 1 | Low-power reference tick, one clock wide |
| sir_rx_pin | input | 1 | Infrared receive pin, 1 = no light |
| uart_rx_pin | input | 1 | Plain serial receive pin |
| uart_txd | output | 1 | Plain serial transmit pin |
| sir_out | output | 1 | Infrared pulse output, 1 = light |
| sir_dec_in | output | 1 | Input toward the pulse decoder |
| uart_rx_core | output | 1 | Plain receive line toward the UART core |

## Verification
The hardest case to reach is a mode change in the middle of a bit, because the pulse shape then depends on a value latched earlier. The stimulus toggles `lowpow_en` at clock counts that drift against the bit boundaries. The bench compares every clock with a reference model that latches the mode only at bit start. Low-power widths are measured at two 16x tick rates, which shows that the width follows only the reference tick. Back-to-back zero bits check that pulses stay inside their own bit.

// File: rtl/sir_pulse_enc.sv
module sir_pulse_enc #(
  parameter int PHASES     = 16,
  parameter int WIN_START  = 7,
  parameter int WIN_LEN    = 3,
  parameter int LP_PERIODS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uart_en,
  input  logic sir_en,
  input  logic lowpow_en,
  input  logic loop_en,
  input  logic sir_test,
  input  logic baud_tick,
  input  logic bit_start,
  input  logic tx_bit,
  input  logic lp_tick,
  input  logic sir_rx_pin,
  input  logic uart_rx_pin,
  output logic uart_txd,
  output logic sir_out,
  output logic sir_dec_in,
  output logic uart_rx_core
);
  localparam int PW      = $clog2(PHASES);
  localparam int CW      = $clog2(LP_PERIODS + 1);
  localparam int WIN_END = WIN_START + WIN_LEN - 1;
  localparam logic [PW-1:0] LAST_PH  = PW'(PHASES - 1);
  localparam logic [PW-1:0] PRE_WIN  = PW'(WIN_START - 1);
  localparam logic [PW-1:0] WIN_LO   = PW'(WIN_START);
  localparam logic [PW-1:0] WIN_HI   = PW'(WIN_END);
  localparam logic [CW-1:0] LP_LAST  = CW'(LP_PERIODS - 1);

  logic [PW-1:0] phase;
  logic          bit_q;
  logic          mode_q;
  logic          lp_busy;
  logic [CW-1:0] lp_cnt;

  wire sir_active = uart_en & sir_en;
  wire bit_tick   = baud_tick & bit_start;
  wire enter_win  = baud_tick & ~bit_start & (phase == PRE_WIN);
  wire in_win     = (phase >= WIN_LO) && (phase <= WIN_HI);
  wire lp_launch  = enter_win & ~bit_q & mode_q;
  wire pulse_nxt  = sir_active & ~bit_q & (mode_q ? lp_busy : in_win);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= LAST_PH;
      bit_q  <= 1'b1;
      mode_q <= 1'b0;
    end else if (bit_tick) begin
      phase  <= '0;
      bit_q  <= tx_bit;
      mode_q <= lowpow_en;
    end else if (baud_tick && phase != LAST_PH) begin
      phase  <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_busy <= 1'b0;
      lp_cnt  <= '0;
    end else if (lp_launch) begin
      lp_busy <= 1'b1;
      lp_cnt  <= '0;
    end else if (bit_tick) begin
      lp_busy <= 1'b0;
    end else if (lp_busy && lp_tick) begin
      lp_cnt  <= lp_cnt + 1'b1;
      if (lp_cnt == LP_LAST) lp_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sir_out <= 1'b0;
    else        sir_out <= pulse_nxt;
  end

  assign uart_txd     = sir_active | tx_bit;
  assign uart_rx_core = sir_active | uart_rx_pin;
  assign sir_dec_in   = ~sir_active ? 1'b1 :
                        (loop_en & sir_test) ? ~sir_out : sir_rx_pin;

  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sir_active) |-> !sir_out);  // R3
  AST_BIT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> ##1 !sir_out);  // R7
  AST_LP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_busy && lp_tick && !lp_launch && !bit_tick && lp_cnt == LP_LAST) |=> !lp_busy);  // R2
  AST_RISE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sir_out) |-> !bit_q);  // R1
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(mode_q));  // R9
endmodule

// File: tb/sir_pulse_enc_tb_top.sv
`timescale 1ns/1ps
module sir_pulse_enc_tb_top;
  logic clk = 0, rst_n = 0;
  logic uart_en = 0, sir_en = 0, lowpow_en = 0, loop_en = 0, sir_test = 0;
  logic baud_tick = 0, bit_start = 0, tx_bit = 1, lp_tick = 0;
  logic sir_rx_pin = 1, uart_rx_pin = 1;
  logic uart_txd, sir_out, sir_dec_in, uart_rx_core;

  always #4 clk = ~clk;

  sir_pulse_enc dut_i (
    .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .sir_en(sir_en),
    .lowpow_en(lowpow_en), .loop_en(loop_en), .sir_test(sir_test),
    .baud_tick(baud_tick), .bit_start(bit_start), .tx_bit(tx_bit),
    .lp_tick(lp_tick), .sir_rx_pin(sir_rx_pin), .uart_rx_pin(uart_rx_pin),
    .uart_txd(uart_txd), .sir_out(sir_out), .sir_dec_in(sir_dec_in),
    .uart_rx_core(uart_rx_core));

  int checks = 0, fails = 0;
  int cyc = 0, tc = 0, bi = 0, div = 4, lpdiv = 5;
  bit [7:0] pat = 8'b0110_0010;
  bit wobble = 0;
  int run_len = 0, wmin = 1000, wmax = 0, pulses = 0, dec_low = 0, loop_bad = 0, txd_low = 0;
  bit prev_out = 0;

  int m_ph = 15, m_cnt = 0;
  bit m_b = 1, m_m = 0, m_busy = 0, m_out = 0;

  always @(posedge clk) begin
    bit act, nxt, launch;
    if (!rst_n) begin
      m_ph = 15; m_b = 1; m_m = 0; m_busy = 0; m_cnt = 0; m_out = 0;
    end else begin
      act = uart_en && sir_en;
      nxt = act && !m_b && (m_m ? m_busy : (m_ph >= 7 && m_ph <= 9));
      launch = baud_tick && !bit_start && m_ph == 6 && !m_b && m_m;
      if (launch) begin m_busy = 1; m_cnt = 0; end
      else if (baud_tick && bit_start) m_busy = 0;
      else if (m_busy && lp_tick) begin
        m_cnt++;
        if (m_cnt == 3) m_busy = 0;
      end
      if (baud_tick && bit_start) begin m_ph = 0; m_b = tx_bit; m_m = lowpow_en; end
      else if (baud_tick && m_ph < 15) m_ph++;
      m_out = nxt;
    end
  end

  task automatic chk(string tag, logic actual, logic expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cyc, actual, expected);
    end
  endtask

  task automatic chk_int(string tag, bit ok, int actual, int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic step();
    bit act;
    @(negedge clk);
    act = uart_en && sir_en;
    chk(!act ? "R3/R5 sir_out" : (m_m ? "R2/R7/R9 sir_out" : "R1/R7/R9 sir_out"), sir_out, m_out);
    chk("R4 uart_txd", uart_txd, act ? 1'b1 : tx_bit);
    chk("R4 uart_rx_core", uart_rx_core, act ? 1'b1 : uart_rx_pin);
    chk("R3/R6 sir_dec_in", sir_dec_in, !act ? 1'b1 : ((loop_en && sir_test) ? !m_out : sir_rx_pin));
    if (sir_out) run_len++;
    else if (run_len > 0) begin
      if (run_len < wmin) wmin = run_len;
      if (run_len > wmax) wmax = run_len;
      run_len = 0;
    end
    if (sir_out && !prev_out) pulses++;
    prev_out = sir_out;
    if (!sir_dec_in) dec_low++;
    if (sir_dec_in !== !sir_out) loop_bad++;
    if (!uart_txd) txd_low++;
    cyc++;
    baud_tick = (cyc % div == 0);
    bit_start = 0;
    if (baud_tick) begin
      if (tc % 16 == 0) begin
        bit_start = 1;
        tx_bit = pat[bi % 8];
        bi++;
      end
      tc++;
    end
    lp_tick = (cyc % lpdiv == 0);
    sir_rx_pin = (cyc % 7 < 3);
    uart_rx_pin = (cyc % 5 < 2);
    if (wobble && cyc % 37 == 0) lowpow_en = ~lowpow_en;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clear_stats();
    run_len = 0; wmin = 1000; wmax = 0; pulses = 0; dec_low = 0; loop_bad = 0; txd_low = 0;
  endtask

  task automatic realign(int d);
    div = d; cyc = 0; tc = 0;
    run(16 * d * 2);
    clear_stats();
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    run(4);
    chk("R8 sir_out reset", sir_out, 1'b0);
    chk("R8 sir_dec_in reset", sir_dec_in, 1'b1);
    rst_n = 1;
    uart_en = 1; sir_en = 1;
    clear_stats();
    run(8);
    chk_int("R8 no pulse before first bit", pulses == 0, pulses, 0);

    realign(4);
    run(16 * 4 * 16);
    chk_int("R1 width div4 min", wmin == 12, wmin, 12);
    chk_int("R1 width div4 max", wmax == 12, wmax, 12);
    chk_int("R7 pulses per zero bits", pulses >= 9 && pulses <= 11, pulses, 10);
    chk_int("R4 txd held high", txd_low == 0, txd_low, 0);

    realign(8);
    run(16 * 8 * 16);
    chk_int("R1 width div8", wmin == 24 && wmax == 24, wmax, 24);

    lowpow_en = 1;
    realign(4);
    run(16 * 4 * 16);
    chk_int("R2 lp width div4 min", wmin >= 11, wmin, 11);
    chk_int("R2 lp width div4 max", wmax <= 15, wmax, 15);
    realign(8);
    run(16 * 8 * 16);
    chk_int("R2 lp width div8", wmin >= 11 && wmax <= 15, wmax, 15);

    wobble = 1;
    realign(4);
    run(16 * 4 * 24);
    wobble = 0; lowpow_en = 0;

    uart_en = 0; sir_en = 1;
    realign(4);
    run(16 * 4 * 8);
    chk_int("R5 no pulses with uart off", pulses == 0, pulses, 0);
    chk_int("R5 txd passes through", txd_low > 0, txd_low, 1);

    uart_en = 1; sir_en = 0;
    realign(4);
    run(16 * 4 * 8);
    chk_int("R3 no pulses when sir off", pulses == 0, pulses, 0);
    chk_int("R3 decoder input held", dec_low == 0, dec_low, 0);

    sir_en = 1; loop_en = 1; sir_test = 1;
    realign(4);
    run(16 * 4 * 8);
    chk_int("R6 loopback inverted", loop_bad == 0, loop_bad, 0);
    chk_int("R6 loopback pulses seen", dec_low > 0, dec_low, 1);
    sir_test = 0;
    realign(4);
    run(16 * 4 * 4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule